// File: doc/BRIEF.md
# Armed circular capture controller

This block sequences sample capture for a two-channel oscilloscope whose sample memory is a circular buffer of 16384 entries per channel. Software writes a control word to arm the capture or to clear it, and selects a trigger source. The post-trigger count says how many decimated samples still go into memory once the trigger has fired. While armed, the controller raises a write enable on every decimated sample and steps a wrapping write pointer. On the first accepted trigger it stores the current write address as the trigger pointer. It then counts down the post-trigger samples, stops writing and disarms.

The trigger source is a 3-bit code. Code 0 never triggers. Code 1 triggers at once. Codes 2 to 7 pick one of six pulse inputs: the channel A and channel B comparators (rising and falling) and two external inputs. The live write pointer, the trigger pointer and the triggered flag are outputs, so the surrounding register file can show them to software. The sample memory, the register file and the edge detectors are outside this block.

Top module: `armed_capture_ctrl`

## Requirements
- R1: While rst_n is low and right after its release, wr_ptr_o, trig_ptr_o, triggered_o and wr_en_o are all 0.
- R2: wr_en_o is high only in a cycle where the controller is armed, smp_vld_i is high and the post-trigger count has not run out. A disarmed controller writes nothing.
- R3: Each write cycle advances wr_ptr_o by one in the next cycle, wrapping from 16383 to 0. wr_addr_o equals wr_ptr_o, and the pointer holds in cycles without a write.
- R4: A cycle with ctrl_wr_i high acts on ctrl_i as follows. Bit 1 set returns wr_ptr_o to 0 and clears the armed state, triggered_o and the post-trigger counter. Bit 0 set arms and clears triggered_o, and the pointer carries on from where it stands. With both bits set the block clears and then arms. Bits 31:2 have no effect.
- R5: The source code src_sel_i selects the trigger as follows. 0 is none, 1 is immediate, 2 is A rising, 3 is A falling, 4 is B rising, 5 is B falling, 6 is external 0 and 7 is external 1. Pulses on inputs that are not selected have no effect.
- R6: A trigger is accepted only while armed and not yet triggered. Once triggered_o is high it stays high, and trig_ptr_o holds, until the next control write that sets bit 0 or bit 1.
- R7: When a trigger is accepted, trig_ptr_o takes the value wr_ptr_o had in the accepting cycle, from the next cycle on.
- R8: After the trigger cycle, exactly delay_i further samples are written, counting only cycles with smp_vld_i high. Then the controller disarms. With delay_i = 0 the trigger-cycle sample is the last one written.
- R9: A trigger pulse in the same cycle as an arm or clear control write is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_i | input | 32 | Control word: bit 0 arm, bit 1 clear |
| src_sel_i | input | 3 | Trigger source code |
| delay_i | input | 32 | Post-trigger sample count |
| smp_vld_i | input | 1 | Decimated sample valid strobe |
| a_rise_i | input | 1 | Channel A rising-crossing pulse |
| a_fall_i | input | 1 | Channel A falling-crossing pulse |
| b_rise_i | input | 1 | Channel B rising-crossing pulse |
| b_fall_i | input | 1 | Channel B falling-crossing pulse |
| ext0_i | input | 1 | External trigger pulse 0 |
| ext1_i | input | 1 | External trigger pulse 1 |
| wr_addr_o | output | 14 | Buffer write address |
| wr_en_o | output | 1 | Buffer write enable |
| wr_ptr_o | output | 14 | Live write pointer |
| trig_ptr_o | output | 14 | Write address latched at the trigger |
| triggered_o | output | 1 | Trigger has been accepted |

## Verification
A wrong armed or finished state shows up on wr_en_o in the same cycle as the next sample strobe: there is either one write too many or one missing. A wrong pointer shows up in the address of the very next write. A bad post-trigger count shifts the final pointer, which appears a few samples after the trigger once the captured run is compared against the expected address sequence. A wrong trigger flag shows up one cycle after the accepting pulse, both on triggered_o and in the latched trigger address.

// File: rtl/cap_pkg.sv
package cap_pkg;
   // Trigger source codes (order is decoded by cap_trig_sel)
   typedef enum logic [2:0] {
      SRC_NONE  = 3'd0,
      SRC_NOW   = 3'd1,
      SRC_A_UP  = 3'd2,
      SRC_A_DN  = 3'd3,
      SRC_B_UP  = 3'd4,
      SRC_B_DN  = 3'd5,
      SRC_X0    = 3'd6,
      SRC_X1    = 3'd7
   } cap_src_e;

   localparam int CTL_ARM_BIT = 0;
   localparam int CTL_CLR_BIT = 1;
   localparam int NUM_EVT     = 6;
endpackage

// File: rtl/cap_trig_sel.sv
module cap_trig_sel
   import cap_pkg::*;
(
   input  logic [2:0]         src_sel_i,
   input  logic [NUM_EVT-1:0] evt_i,
   output logic               hit_o
);
   logic [7:0] src_vec;

   // code 0: never, code 1: always, codes 2..7: event pulses
   assign src_vec = {evt_i, 1'b1, 1'b0};

   always_comb begin
      hit_o = src_vec[src_sel_i];
   end
endmodule

// File: rtl/cap_wr_ptr.sv
module cap_wr_ptr #(
   parameter int AW = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          step_i,
   input  logic          cap_i,
   output logic [AW-1:0] ptr_o,
   output logic [AW-1:0] trig_ptr_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_o      <= '0;
         trig_ptr_o <= '0;
      end else begin
         if (clr_i)       ptr_o <= '0;
         else if (step_i) ptr_o <= ptr_o + 1'b1;
         if (cap_i)       trig_ptr_o <= ptr_o;
      end
   end
endmodule

// File: rtl/cap_seq.sv
module cap_seq #(
   parameter int DLY_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic             clr_i,
   input  logic             vld_i,
   input  logic             hit_i,
   input  logic [DLY_W-1:0] delay_i,
   output logic             we_o,
   output logic             accept_o,
   output logic             triggered_o
);
   logic             armed_q;
   logic             seen_q;
   logic [DLY_W-1:0] cnt_q;
   logic             done;
   logic             cmd;

   assign cmd      = arm_i | clr_i;
   assign done     = armed_q & seen_q & (cnt_q == '0);
   assign we_o     = armed_q & vld_i & ~done;
   assign accept_o = armed_q & ~seen_q & hit_i & ~cmd;
   assign triggered_o = seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         seen_q  <= 1'b0;
         cnt_q   <= '0;
      end else if (cmd) begin
         if (clr_i) cnt_q <= '0;
         armed_q <= arm_i;
         seen_q  <= 1'b0;
      end else begin
         if (done) armed_q <= 1'b0;
         if (accept_o) begin
            seen_q <= 1'b1;
            cnt_q  <= delay_i;
         end else if (armed_q && seen_q && vld_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/armed_capture_ctrl.sv
module armed_capture_ctrl
   import cap_pkg::*;
#(
   parameter int DEPTH = 16384,
   parameter int DLY_W = 32,
   parameter int CTL_W = 32,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_wr_i,
   input  logic [CTL_W-1:0] ctrl_i,
   input  logic [2:0]       src_sel_i,
   input  logic [DLY_W-1:0] delay_i,
   input  logic             smp_vld_i,
   input  logic             a_rise_i,
   input  logic             a_fall_i,
   input  logic             b_rise_i,
   input  logic             b_fall_i,
   input  logic             ext0_i,
   input  logic             ext1_i,
   output logic [AW-1:0]    wr_addr_o,
   output logic             wr_en_o,
   output logic [AW-1:0]    wr_ptr_o,
   output logic [AW-1:0]    trig_ptr_o,
   output logic             triggered_o
);
   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end
   if (CTL_W < 2) begin : g_bad_ctl
      $error("CTL_W must hold the arm and clear bits");
   end
   if (DLY_W < AW + 1) begin : g_bad_dly
      $error("DLY_W must cover a full buffer of post-trigger samples");
   end

   logic               arm_cmd;
   logic               clr_cmd;
   logic               hit;
   logic               accept;
   logic [NUM_EVT-1:0] evt;

   if (CTL_W > 2) begin : g_ctl_spare
      logic ctl_unused;
      assign ctl_unused = ^ctrl_i[CTL_W-1:2];
   end

   assign arm_cmd = ctrl_wr_i & ctrl_i[CTL_ARM_BIT];
   assign clr_cmd = ctrl_wr_i & ctrl_i[CTL_CLR_BIT];
   assign evt     = {ext1_i, ext0_i, b_fall_i, b_rise_i, a_fall_i, a_rise_i};

   cap_trig_sel i_trig_sel (
      .src_sel_i (src_sel_i),
      .evt_i     (evt),
      .hit_o     (hit)
   );

   cap_seq #(.DLY_W(DLY_W)) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm_i       (arm_cmd),
      .clr_i       (clr_cmd),
      .vld_i       (smp_vld_i),
      .hit_i       (hit),
      .delay_i     (delay_i),
      .we_o        (wr_en_o),
      .accept_o    (accept),
      .triggered_o (triggered_o)
   );

   cap_wr_ptr #(.AW(AW)) i_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (clr_cmd),
      .step_i     (wr_en_o),
      .cap_i      (accept),
      .ptr_o      (wr_ptr_o),
      .trig_ptr_o (trig_ptr_o)
   );

   assign wr_addr_o = wr_ptr_o;
endmodule

// File: rtl/cap_ctrl_chk.sv
module cap_ctrl_chk #(
   parameter int AW = 14
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ctrl_wr_i,
   input logic          arm_bit,
   input logic          clr_bit,
   input logic          smp_vld_i,
   input logic          wr_en_o,
   input logic [AW-1:0] wr_ptr_o,
   input logic [AW-1:0] trig_ptr_o,
   input logic          triggered_o
);
   logic clr_c;
   logic cmd_c;
   assign clr_c = ctrl_wr_i & clr_bit;
   assign cmd_c = ctrl_wr_i & (arm_bit | clr_bit);

   AST_WE_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> smp_vld_i); // R2
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && !clr_c) |=> wr_ptr_o == $past(wr_ptr_o) + 1'b1); // R3
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_o && !clr_c) |=> $stable(wr_ptr_o)); // R3
   AST_CLR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      clr_c |=> (wr_ptr_o == '0 && !triggered_o)); // R4
   AST_TRIG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (triggered_o && !cmd_c) |=> (triggered_o && $stable(trig_ptr_o))); // R6
   AST_TPTR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(triggered_o) |-> trig_ptr_o == $past(wr_ptr_o)); // R7
   AST_CMD_BLOCKS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_c |=> !triggered_o); // R9
endmodule

bind armed_capture_ctrl cap_ctrl_chk #(.AW(AW)) i_cap_ctrl_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctrl_wr_i   (ctrl_wr_i),
   .arm_bit     (ctrl_i[0]),
   .clr_bit     (ctrl_i[1]),
   .smp_vld_i   (smp_vld_i),
   .wr_en_o     (wr_en_o),
   .wr_ptr_o    (wr_ptr_o),
   .trig_ptr_o  (trig_ptr_o),
   .triggered_o (triggered_o)
);

// File: tb/test_armed_capture_ctrl.sv
module test_armed_capture_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctrl_wr_i = 1'b0;
   logic [31:0]   ctrl_i = '0;
   logic [2:0]    src_sel_i = '0;
   logic [31:0]   delay_i = '0;
   logic          smp_vld_i = 1'b0;
   logic [5:0]    ev = '0;
   logic [AW-1:0] wr_addr_o, wr_ptr_o, trig_ptr_o;
   logic          wr_en_o, triggered_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   armed_capture_ctrl i_armed_capture_ctrl (
      .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr_i), .ctrl_i(ctrl_i),
      .src_sel_i(src_sel_i), .delay_i(delay_i), .smp_vld_i(smp_vld_i),
      .a_rise_i(ev[0]), .a_fall_i(ev[1]), .b_rise_i(ev[2]), .b_fall_i(ev[3]),
      .ext0_i(ev[4]), .ext1_i(ev[5]),
      .wr_addr_o(wr_addr_o), .wr_en_o(wr_en_o), .wr_ptr_o(wr_ptr_o),
      .trig_ptr_o(trig_ptr_o), .triggered_o(triggered_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [AW-1:0] exp_q[$];

   // reference state
   bit            m_armed, m_seen;
   logic [31:0]   m_cnt;
   logic [AW-1:0] m_ptr, m_tptr;

   task automatic chk(string rq, logic [31:0] act, logic [31:0] exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // monitor: compare every write against the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_en_o === 1'b1) begin
            if (exp_q.size() == 0) chk("R2", 32'd1, 32'd0, "unexpected write");
            else chk("R3", {18'd0, wr_addr_o}, {18'd0, exp_q.pop_front()}, "write address");
         end else if (exp_q.size() != 0) begin
            chk("R2", 32'd0, 32'd1, "missing write");
            void'(exp_q.pop_front());
         end
      end
   end

   // driver: one cycle of stimulus, scoreboard push, model update
   task automatic step(bit vld, logic [5:0] e, bit cw = 1'b0, logic [31:0] cv = '0);
      bit done, we, acc, sel_hit;
      smp_vld_i = vld; ev = e; ctrl_wr_i = cw; ctrl_i = cv;
      done = m_armed && m_seen && (m_cnt == 0);
      we   = m_armed && vld && !done;
      sel_hit = (src_sel_i == 3'd1) || (src_sel_i >= 3'd2 && e[src_sel_i - 3'd2]);
      acc  = m_armed && !m_seen && sel_hit;
      if (we) exp_q.push_back(m_ptr);
      if (cw && (cv[0] || cv[1])) begin
         if (cv[1]) begin m_ptr = '0; m_cnt = '0; end
         else if (we) m_ptr = m_ptr + 1'b1;
         m_armed = cv[0]; m_seen = 1'b0;
      end else begin
         if (acc) begin m_seen = 1'b1; m_tptr = m_ptr; m_cnt = delay_i; end
         else if (m_armed && m_seen && vld && m_cnt != 0) m_cnt = m_cnt - 1;
         if (done) m_armed = 1'b0;
         if (we) m_ptr = m_ptr + 1'b1;
      end
      @(posedge clk); #1;
      smp_vld_i = 1'b0; ev = '0; ctrl_wr_i = 1'b0; ctrl_i = '0;
   endtask

   task automatic chk_state(string rq);
      chk(rq, {18'd0, wr_ptr_o}, {18'd0, m_ptr}, "write pointer");
      chk(rq, {31'd0, triggered_o}, {31'd0, m_seen}, "triggered");
      chk(rq, {18'd0, trig_ptr_o}, {18'd0, m_tptr}, "trigger pointer");
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      chk("WATCHDOG", 32'd1, 32'd0, "timeout");
      report();
   end

   initial begin
      m_armed = 0; m_seen = 0; m_cnt = '0; m_ptr = '0; m_tptr = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1", {31'd0, wr_en_o}, 32'd0, "wr_en in reset");
      chk_state("R1");
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk_state("R1");

      // R2: disarmed, strobes do nothing
      repeat (5) step(1, 6'h3f);
      chk_state("R2");

      // R4: upper control bits only
      step(1, 0, 1, 32'hFFFF_FFFC);
      repeat (3) step(1, 0);
      chk_state("R4");

      // R5: code 0 never triggers
      src_sel_i = 3'd0; delay_i = 3;
      step(1, 0, 1, 32'h1);
      for (int i = 0; i < 20; i++) step(i % 3 != 0, 6'h3f);
      chk_state("R5");

      // R5/R6/R7/R8: channel B rising with gaps in the strobe
      src_sel_i = 3'd4;
      step(1, 6'b111011);
      chk("R5", {31'd0, triggered_o}, 32'd0, "unselected pulses");
      step(0, 6'b000100);
      chk_state("R7");
      for (int i = 0; i < 10; i++) step(i % 2 == 0, 6'b000100);
      chk_state("R8");
      chk("R6", {31'd0, triggered_o}, 32'd1, "triggered sticky");

      // R4: rearm continues from the current pointer
      step(0, 0, 1, 32'h1);
      step(1, 0);
      chk_state("R4");

      // R4: clear
      step(1, 0, 1, 32'h2);
      chk_state("R4");

      // R9: pulse during arm write is ignored
      src_sel_i = 3'd6; delay_i = 2;
      step(1, 6'b010000, 1, 32'h3);
      chk("R9", {31'd0, triggered_o}, 32'd0, "trigger in arm cycle");
      step(1, 6'b010000);
      repeat (5) step(1, 0);
      chk_state("R9");

      // R5/R8: every pulse source, delay 0
      delay_i = 0;
      for (int s = 2; s < 8; s++) begin
         src_sel_i = 3'(s);
         step(1, 0, 1, 32'h3);
         step(1, ~(6'd1 << (s - 2)));
         chk("R5", {31'd0, triggered_o}, 32'd0, "other sources");
         step(1, 6'd1 << (s - 2));
         repeat (3) step(1, 0);
         chk_state("R8");
      end

      // R5: immediate trigger, delay 5
      src_sel_i = 3'd1; delay_i = 5;
      step(1, 0, 1, 32'h3);
      for (int i = 0; i < 12; i++) step(i != 4, 0);
      chk_state("R5");

      // R3: wrap of the pointer
      src_sel_i = 3'd0;
      step(1, 0, 1, 32'h3);
      repeat (16385) step(1, 0);
      chk("R3", {18'd0, wr_ptr_o}, 32'd1, "wrapped pointer");
      step(0, 0, 1, 32'h2);
      chk_state("R4");

      chk("R2", exp_q.size(), 32'd0, "scoreboard drained");
      report();
   end
endmodule